// File: doc/BRIEF.md
# ADC Input Pin Open/Short Diagnostic Sequencer

This block checks whether an analog input pin of a converter is healthy, shorted to one of the reference rails, or left open. After a start strobe in idle, it latches the selected channel and asks the attached converter for three conversions of that channel. The first uses self-test with the low reference. The second uses self-test with the high reference. The third is an ordinary conversion. For the two self-test conversions it also asks for a doubled sampling window. It keeps the three result codes, called Vd, Vu and Vn in that order, and sorts them into a two-bit condition code that is reported with a one-cycle done strobe.

The state sequence is S_IDLE → S_CONV_LO → S_CONV_HI → S_CONV_NORM → S_CLASSIFY → S_DONE → S_IDLE. The transitions are:
- start: S_IDLE to S_CONV_LO.
- lo_valid: S_CONV_LO to S_CONV_HI.
- hi_valid: S_CONV_HI to S_CONV_NORM.
- norm_valid: S_CONV_NORM to S_CLASSIFY.
- decide: S_CLASSIFY to S_DONE, unconditional.
- report: S_DONE to S_IDLE, unconditional.

Each conversion state holds its request until the converter returns a valid result. The rail codes and the tolerance that defines "near a rail" are configuration inputs.

Top module: `adc_pin_diag`

## Requirements
- R1: After start in S_IDLE, the block requests conversion of the latched channel with selftest_o=1, ref_hi_o=0 and samp_double_o=1. The returned result is stored as Vd.
- R2: The second request uses selftest_o=1, ref_hi_o=1 and samp_double_o=1. Its result is stored as Vu.
- R3: The third request uses selftest_o=0 and samp_double_o=0. Its result is stored as Vn.
- R4: Once conv_req_o rises, it stays high until a cycle with res_valid_i=1. Channel, selftest and reference outputs do not change while it is high.
- R5: cond_o=00 (good) when rail_lo < Vd < Vn < Vu < rail_hi. All comparisons are strict and unsigned. This rule is checked first.
- R6: cond_o=01 (shorted high) when Vn = Vu = rail_hi and Vd ≥ rail_hi − tol. This rule is checked second.
- R7: cond_o=10 (shorted low) when Vn = Vd = rail_lo and Vu ≤ rail_lo + tol. This rule is checked third.
- R8: cond_o=11 (open) with indet_o=0 when Vu = rail_hi and Vd = rail_lo, whatever Vn is. This rule is checked fourth.
- R9: If no rule matches, cond_o=11 and indet_o=1. Otherwise indet_o=0.
- R10: done_o is high for exactly one cycle, in the cycle after the third result is accepted plus one. cond_o and indet_o change only in that cycle and hold until the next done.
- R11: A start strobe while the block is not in S_IDLE is ignored. The channel and the three-request sequence are not affected.
- R12: Synchronous reset returns the block to S_IDLE with conv_req_o=0, done_o=0, cond_o=00 and indet_o=0, and clears the stored results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, accepted only in idle |
| chan_i | input | CH_W | Channel to diagnose |
| conv_req_o | output | 1 | Conversion request to the converter |
| conv_chan_o | output | CH_W | Channel for the requested conversion |
| selftest_o | output | 1 | Self-test enable for this conversion |
| ref_hi_o | output | 1 | Self-test reference: 1 = high rail, 0 = low rail |
| samp_double_o | output | 1 | Request a doubled sampling window |
| res_valid_i | input | 1 | Converter result valid |
| res_data_i | input | CODE_W | Converter result code |
| rail_lo_i | input | CODE_W | Code read at the low rail |
| rail_hi_i | input | CODE_W | Code read at the high rail |
| tol_i | input | CODE_W | Tolerance, in codes, for "near a rail" |
| done_o | output | 1 | One-cycle completion strobe |
| cond_o | output | 2 | 00 good, 01 shorted high, 10 shorted low, 11 open |
| indet_o | output | 1 | No rule matched (reported as open) |

## Verification
The hardest situations to reach from the ports are a start strobe that arrives in the middle of a sequence and a reset that arrives in the middle of a sequence. The bench uses a converter stub that logs which step it is serving. It fires the extra start or the reset exactly when the stub has answered the first request, so the block is then waiting in S_CONV_HI. The stub also holds each answer back for several cycles. This checks that the request and its qualifiers stay put while the block waits. Rail codes are moved away from 0 and full scale so that boundary values fall on the strict comparisons.

// File: rtl/adc_pin_diag_pkg.sv
package adc_pin_diag_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CONV_LO,
        S_CONV_HI,
        S_CONV_NORM,
        S_CLASSIFY,
        S_DONE
    } diag_state_t;

    typedef enum logic [1:0] {
        COND_GOOD     = 2'b00,
        COND_SHORT_HI = 2'b01,
        COND_SHORT_LO = 2'b10,
        COND_OPEN     = 2'b11
    } pin_cond_t;

endpackage

// File: rtl/adc_pin_diag_seq.sv
module adc_pin_diag_seq
    import adc_pin_diag_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            res_valid_i,
    output logic            conv_req_o,
    output logic [CH_W-1:0] conv_chan_o,
    output logic            selftest_o,
    output logic            ref_hi_o,
    output logic            samp_double_o,
    output logic            ld_vd_o,
    output logic            ld_vu_o,
    output logic            ld_vn_o,
    output logic            ld_cond_o,
    output logic            done_o
);

    diag_state_t     state_q, state_d;
    logic [CH_W-1:0] chan_q;

    // state register and channel latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                chan_q <= chan_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start_i)     state_d = S_CONV_LO;
            S_CONV_LO:   if (res_valid_i) state_d = S_CONV_HI;
            S_CONV_HI:   if (res_valid_i) state_d = S_CONV_NORM;
            S_CONV_NORM: if (res_valid_i) state_d = S_CLASSIFY;
            S_CLASSIFY:                   state_d = S_DONE;
            S_DONE:                       state_d = S_IDLE;
            default:                      state_d = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        conv_req_o    = 1'b0;
        selftest_o    = 1'b0;
        ref_hi_o      = 1'b0;
        samp_double_o = 1'b0;
        ld_vd_o       = 1'b0;
        ld_vu_o       = 1'b0;
        ld_vn_o       = 1'b0;
        ld_cond_o     = 1'b0;
        done_o        = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_CONV_LO: begin
                conv_req_o    = 1'b1;
                selftest_o    = 1'b1;
                samp_double_o = 1'b1;
                ld_vd_o       = res_valid_i;
            end
            S_CONV_HI: begin
                conv_req_o    = 1'b1;
                selftest_o    = 1'b1;
                ref_hi_o      = 1'b1;
                samp_double_o = 1'b1;
                ld_vu_o       = res_valid_i;
            end
            S_CONV_NORM: begin
                conv_req_o = 1'b1;
                ld_vn_o    = res_valid_i;
            end
            S_CLASSIFY: ld_cond_o = 1'b1;
            S_DONE:     done_o    = 1'b1;
            default: ;
        endcase
    end

    assign conv_chan_o = chan_q;

endmodule

// File: rtl/adc_pin_diag_class.sv
module adc_pin_diag_class
    import adc_pin_diag_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] vd_i,
    input  logic [CODE_W-1:0] vu_i,
    input  logic [CODE_W-1:0] vn_i,
    input  logic [CODE_W-1:0] rail_lo_i,
    input  logic [CODE_W-1:0] rail_hi_i,
    input  logic [CODE_W-1:0] tol_i,
    output pin_cond_t         cond_o,
    output logic              indet_o
);

    logic [CODE_W-1:0] dist_vd_hi, dist_vu_lo;
    logic              is_good, is_short_hi, is_short_lo, is_open;

    always_comb begin
        dist_vd_hi = (vd_i >= rail_hi_i) ? '0 : (rail_hi_i - vd_i);
        dist_vu_lo = (vu_i <= rail_lo_i) ? '0 : (vu_i - rail_lo_i);

        is_good     = (rail_lo_i < vd_i) && (vd_i < vn_i) &&
                      (vn_i < vu_i) && (vu_i < rail_hi_i);
        is_short_hi = (vn_i == rail_hi_i) && (vu_i == rail_hi_i) &&
                      (dist_vd_hi <= tol_i);
        is_short_lo = (vn_i == rail_lo_i) && (vd_i == rail_lo_i) &&
                      (dist_vu_lo <= tol_i);
        is_open     = (vu_i == rail_hi_i) && (vd_i == rail_lo_i);

        indet_o = 1'b0;
        if (is_good)          cond_o = COND_GOOD;
        else if (is_short_hi) cond_o = COND_SHORT_HI;
        else if (is_short_lo) cond_o = COND_SHORT_LO;
        else if (is_open)     cond_o = COND_OPEN;
        else begin
            cond_o  = COND_OPEN;
            indet_o = 1'b1;
        end
    end

endmodule

// File: rtl/adc_pin_diag.sv
module adc_pin_diag
    import adc_pin_diag_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    output logic              conv_req_o,
    output logic [CH_W-1:0]   conv_chan_o,
    output logic              selftest_o,
    output logic              ref_hi_o,
    output logic              samp_double_o,
    input  logic              res_valid_i,
    input  logic [CODE_W-1:0] res_data_i,
    input  logic [CODE_W-1:0] rail_lo_i,
    input  logic [CODE_W-1:0] rail_hi_i,
    input  logic [CODE_W-1:0] tol_i,
    output logic              done_o,
    output logic [1:0]        cond_o,
    output logic              indet_o
);

    logic              ld_vd, ld_vu, ld_vn, ld_cond;
    logic [CODE_W-1:0] vd_q, vu_q, vn_q;
    pin_cond_t         cond_next, cond_q;
    logic              indet_next, indet_q;

    adc_pin_diag_seq #(.CH_W(CH_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .chan_i       (chan_i),
        .res_valid_i  (res_valid_i),
        .conv_req_o   (conv_req_o),
        .conv_chan_o  (conv_chan_o),
        .selftest_o   (selftest_o),
        .ref_hi_o     (ref_hi_o),
        .samp_double_o(samp_double_o),
        .ld_vd_o      (ld_vd),
        .ld_vu_o      (ld_vu),
        .ld_vn_o      (ld_vn),
        .ld_cond_o    (ld_cond),
        .done_o       (done_o)
    );

    // result store
    always_ff @(posedge clk) begin
        if (rst) begin
            vd_q <= '0;
            vu_q <= '0;
            vn_q <= '0;
        end else begin
            if (ld_vd) vd_q <= res_data_i;
            if (ld_vu) vu_q <= res_data_i;
            if (ld_vn) vn_q <= res_data_i;
        end
    end

    adc_pin_diag_class #(.CODE_W(CODE_W)) u_class (
        .vd_i     (vd_q),
        .vu_i     (vu_q),
        .vn_i     (vn_q),
        .rail_lo_i(rail_lo_i),
        .rail_hi_i(rail_hi_i),
        .tol_i    (tol_i),
        .cond_o   (cond_next),
        .indet_o  (indet_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q  <= COND_GOOD;
            indet_q <= 1'b0;
        end else if (ld_cond) begin
            cond_q  <= cond_next;
            indet_q <= indet_next;
        end
    end

    assign cond_o  = cond_q;
    assign indet_o = indet_q;

endmodule

// File: rtl/adc_pin_diag_chk.sv
module adc_pin_diag_chk #(
    parameter int CODE_W = 12,
    parameter int CH_W   = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            conv_req_o,
    input logic [CH_W-1:0] conv_chan_o,
    input logic            selftest_o,
    input logic            ref_hi_o,
    input logic            samp_double_o,
    input logic            res_valid_i,
    input logic            done_o,
    input logic [1:0]      cond_o,
    input logic            indet_o
);

    assert_double_window_R1: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && selftest_o) |-> samp_double_o);

    assert_normal_window_R3: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && !selftest_o) |-> !samp_double_o);

    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_req_o && !res_valid_i) |=> (conv_req_o && $stable(selftest_o) &&
                                          $stable(ref_hi_o) && $stable(conv_chan_o)));

    assert_indet_open_R9: assert property (@(posedge clk) disable iff (rst)
        indet_o |-> (cond_o == 2'b11));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_no_req_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !conv_req_o);

    assert_cond_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($stable(cond_o) && $stable(indet_o))) |-> done_o);

endmodule

bind adc_pin_diag adc_pin_diag_chk #(.CODE_W(CODE_W), .CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_req_o   (conv_req_o),
    .conv_chan_o  (conv_chan_o),
    .selftest_o   (selftest_o),
    .ref_hi_o     (ref_hi_o),
    .samp_double_o(samp_double_o),
    .res_valid_i  (res_valid_i),
    .done_o       (done_o),
    .cond_o       (cond_o),
    .indet_o      (indet_o)
);

// File: tb/sim_adc_pin_diag.sv
`timescale 1ns/1ps
module sim_adc_pin_diag;

    localparam int CODE_W = 12;
    localparam int CH_W   = 4;
    localparam int LAT    = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [CH_W-1:0]   chan_i = '0;
    logic              conv_req_o;
    logic [CH_W-1:0]   conv_chan_o;
    logic              selftest_o, ref_hi_o, samp_double_o;
    logic              res_valid_i = 1'b0;
    logic [CODE_W-1:0] res_data_i = '0;
    logic [CODE_W-1:0] rail_lo_i = '0;
    logic [CODE_W-1:0] rail_hi_i = 12'hFFF;
    logic [CODE_W-1:0] tol_i = 12'd8;
    logic              done_o;
    logic [1:0]        cond_o;
    logic              indet_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_pin_diag #(.CODE_W(CODE_W), .CH_W(CH_W)) u0 (.*);

    // converter stub
    logic [CODE_W-1:0] stub_vd, stub_vu, stub_vn;
    int                wait_cnt = 0;
    int                step = 0;
    int                drop_err = 0;
    logic              log_st [3];
    logic              log_rh [3];
    logic              log_sd [3];
    logic [CH_W-1:0]   log_ch [3];

    always @(posedge clk) begin
        if (rst) begin
            res_valid_i <= 1'b0;
            wait_cnt    <= 0;
        end else if (res_valid_i) begin
            res_valid_i <= 1'b0;
            wait_cnt    <= 0;
        end else if (conv_req_o) begin
            if (wait_cnt == LAT) begin
                res_valid_i <= 1'b1;
                res_data_i  <= !selftest_o ? stub_vn : (ref_hi_o ? stub_vu : stub_vd);
                if (step < 3) begin
                    log_st[step] <= selftest_o;
                    log_rh[step] <= ref_hi_o;
                    log_sd[step] <= samp_double_o;
                    log_ch[step] <= conv_chan_o;
                end
                step <= step + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else if (wait_cnt != 0) begin
            drop_err <= drop_err + 1;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done_o) begin ok = 1; break; end
        end
    endtask

    task automatic pulse_start(logic [CH_W-1:0] ch);
        @(negedge clk);
        start_i = 1'b1;
        chan_i  = ch;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_case(string req, logic [CH_W-1:0] ch, int vd, int vu, int vn,
                            int exp_cond, int exp_ind);
        bit ok;
        stub_vd = CODE_W'(vd);
        stub_vu = CODE_W'(vu);
        stub_vn = CODE_W'(vn);
        step = 0;
        pulse_start(ch);
        wait_done(ok);
        check({req, " done seen"}, int'(ok), 1);
        check({req, " cond"}, int'(cond_o), exp_cond);
        check({req, " indet"}, int'(indet_o), exp_ind);
        @(negedge clk);
        check("R10 done one cycle", int'(done_o), 0);
        check("R10 cond held", int'(cond_o), exp_cond);
    endtask

    task automatic t_reset_state;
        check("R12 reset req", int'(conv_req_o), 0);
        check("R12 reset done", int'(done_o), 0);
        check("R12 reset cond", int'(cond_o), 0);
        check("R12 reset indet", int'(indet_o), 0);
    endtask

    task automatic t_good_and_steps;
        run_case("R5 good", 4'd5, 100, 3000, 2000, 0, 0);
        check("R1 step1 selftest", int'(log_st[0]), 1);
        check("R1 step1 ref", int'(log_rh[0]), 0);
        check("R1 step1 double", int'(log_sd[0]), 1);
        check("R1 step1 chan", int'(log_ch[0]), 5);
        check("R2 step2 selftest", int'(log_st[1]), 1);
        check("R2 step2 ref", int'(log_rh[1]), 1);
        check("R2 step2 double", int'(log_sd[1]), 1);
        check("R3 step3 selftest", int'(log_st[2]), 0);
        check("R3 step3 double", int'(log_sd[2]), 0);
        check("R3 conversions", step, 3);
        check("R4 request held", drop_err, 0);
    endtask

    task automatic t_short_hi;
        run_case("R6 short high", 4'd1, 4090, 4095, 4095, 1, 0);
        run_case("R9 short high out of tol", 4'd1, 4000, 4095, 4095, 3, 1);
    endtask

    task automatic t_short_lo;
        run_case("R7 short low", 4'd2, 0, 8, 0, 2, 0);
        run_case("R9 short low out of tol", 4'd2, 0, 9, 0, 3, 1);
    endtask

    task automatic t_open;
        run_case("R8 open", 4'd3, 0, 4095, 1234, 3, 0);
    endtask

    task automatic t_custom_rails;
        rail_lo_i = 12'd16;
        rail_hi_i = 12'd4000;
        run_case("R5 good custom rails", 4'd4, 17, 3999, 2000, 0, 0);
        run_case("R9 Vd on low rail", 4'd4, 16, 3000, 2000, 3, 1);
        run_case("R8 open custom rails", 4'd4, 16, 4000, 16, 3, 0);
        run_case("R6 short high custom", 4'd4, 3992, 4000, 4000, 1, 0);
        rail_lo_i = 12'd0;
        rail_hi_i = 12'hFFF;
    endtask

    task automatic t_busy_start;
        bit ok;
        stub_vd = 12'd200; stub_vu = 12'd3500; stub_vn = 12'd1500;
        step = 0;
        pulse_start(4'd6);
        while (step < 1) @(negedge clk);
        start_i = 1'b1; chan_i = 4'd9;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(ok);
        check("R11 done", int'(ok), 1);
        check("R11 chan step2", int'(log_ch[1]), 6);
        check("R11 chan step3", int'(log_ch[2]), 6);
        check("R11 cond", int'(cond_o), 0);
        for (int i = 0; i < 8; i++) @(negedge clk);
        check("R11 no restart", int'(conv_req_o), 0);
        check("R11 conversions", step, 3);
    endtask

    task automatic t_mid_reset;
        stub_vd = 12'd0; stub_vu = 12'hFFF; stub_vn = 12'd50;
        step = 0;
        pulse_start(4'd7);
        while (step < 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        @(negedge clk);
        @(negedge clk);
        check("R12 stays idle", int'(conv_req_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_good_and_steps();
        t_short_hi();
        t_short_lo();
        t_open();
        t_custom_rails();
        t_busy_start();
        run_case("R8 open before reset", 4'd0, 0, 4095, 7, 3, 0);
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule